// File: doc/BRIEF.md
# Parallel Prefix Adder

This block adds two N-bit operands and a carry-in with no clocked state. Every column's carry is found by a tree of generate/propagate merge cells rather than by a rippling chain. The carry-in is handled as an extra column placed under bit 0. That column generates exactly when the carry-in is set and never propagates. As a result, the carry into any column is simply the generate term of the span that runs from the column just below it down to that extra column.

The tree has log2 N merge levels. At each level a node combines with the node a power-of-two distance below it, so spans of 2, 4, 8 and more columns are covered in turn until every node reaches the extra column. The sum bits and the carry-out are formed from those span generates in one final stage. N must be a power of two and defaults to 16.

Top module: `prefix_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^N for every input combination.
- R2: `carry_out` equals bit N of the full (N+1)-bit value `op_a` + `op_b` + `carry_in`. When bit N-1 is 1 in both operands, `carry_out` is 1. When bit N-1 is 0 in both operands, `carry_out` is 0.
- R3: With both operands zero, `sum` equals `carry_in` (placed in bit 0) and `carry_out` is 0.
- R4: When the operands have no bit set in common and together cover every bit (`op_a` XOR `op_b` all ones), the carry-in travels through every column. `sum` is all ones when `carry_in` is 0, and all zeros when `carry_in` is 1, and `carry_out` equals `carry_in`.
- R5: The carry-in enters only as the generate of a virtual column below bit 0, and every span that reaches that column has propagate 0. With `carry_in` = 1 the result equals the result with `carry_in` = 0 plus one.
- R6: Bit 0 of `sum` equals `op_a[0]` XOR `op_b[0]` XOR `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the total |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
The bound checker re-evaluates the block on every input change. It compares the full (N+1)-bit total with plain arithmetic. It checks the top-column carry rules and the zero-operand and full-propagate cases. It also confirms that each final-level span propagate is zero, an internal property that the ports cannot show. The bench supplies the evidence the checker cannot. It sweeps a 4-bit copy over every operand and carry-in combination, and it drives the default 16-bit copy with corner patterns and pseudo-random operands. It also compares each result taken with the carry-in set against the same operands taken with it clear.

// File: rtl/pa_pkg.sv
package pa_pkg;

    // Generate/propagate pair for one column or for a span of columns.
    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    // Merge an upper span with the span directly beneath it.
    function automatic pg_t pg_merge(input pg_t upper, input pg_t lower);
        pg_t r;
        r.gen  = upper.gen | (upper.prop & lower.gen);
        r.prop = upper.prop & lower.prop;
        return r;
    endfunction

    // Pair for a single column of two operand bits.
    function automatic pg_t pg_column(input logic x, input logic y);
        pg_t r;
        r.gen  = x & y;
        r.prop = x | y;
        return r;
    endfunction

endpackage

// File: rtl/pa_col_pg.sv
// Leaf pairs. Slot 0 holds the virtual column carrying the carry-in.
// Slot k (k >= 1) holds operand column k-1. Operand column N-1 feeds
// only the carry-out and is handled in the output stage.
module pa_col_pg
    import pa_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]    a,
    input  logic [N-1:0]    b,
    input  logic            cin,
    output pg_t  [N-1:0]    leaf
);

    assign leaf[0] = '{gen: cin, prop: 1'b0};

    for (genvar k = 1; k < N; k++) begin : g_leaf
        assign leaf[k] = pg_column(a[k-1], b[k-1]);
    end

endmodule

// File: rtl/pa_prefix_tree.sv
// Regular log2(N)-level tree. At level l every node merges with the node
// 2^l slots below it. After the last level each slot k spans down to slot 0.
module pa_prefix_tree
    import pa_pkg::*;
#(
    parameter int N = 16
) (
    input  pg_t  [N-1:0]    leaf,
    output logic [N-1:0]    carry,
    output logic [N-1:0]    span_prop
);

    localparam int LEVELS = $clog2(N);

    pg_t [N-1:0] lvl [LEVELS+1];

    assign lvl[0] = leaf;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int DIST = 1 << l;
        for (genvar k = 0; k < N; k++) begin : g_node
            if (k >= DIST) begin : g_merge
                assign lvl[l+1][k] = pg_merge(lvl[l][k], lvl[l][k-DIST]);
            end else begin : g_pass
                assign lvl[l+1][k] = lvl[l][k];
            end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_out
        assign carry[k]     = lvl[LEVELS][k].gen;
        assign span_prop[k] = lvl[LEVELS][k].prop;
    end

endmodule

// File: rtl/pa_sum_stage.sv
// carry[i] is the carry into operand column i.
module pa_sum_stage
    import pa_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]    a,
    input  logic [N-1:0]    b,
    input  logic [N-1:0]    carry,
    output logic [N-1:0]    sum,
    output logic            cout
);

    pg_t top_col;

    assign sum     = a ^ b ^ carry;
    assign top_col = pg_column(a[N-1], b[N-1]);
    assign cout    = top_col.gen | (top_col.prop & carry[N-1]);

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
    import pa_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]    op_a,
    input  logic [N-1:0]    op_b,
    input  logic            carry_in,
    output logic [N-1:0]    sum,
    output logic            carry_out
);

    pg_t  [N-1:0] leaf;
    logic [N-1:0] carry_vec;
    logic [N-1:0] span_prop;

    pa_col_pg #(.N(N)) u_leaf (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .leaf (leaf)
    );

    pa_prefix_tree #(.N(N)) u_tree (
        .leaf      (leaf),
        .carry     (carry_vec),
        .span_prop (span_prop)
    );

    pa_sum_stage #(.N(N)) u_out (
        .a     (op_a),
        .b     (op_b),
        .carry (carry_vec),
        .sum   (sum),
        .cout  (carry_out)
    );

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int N = 16
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         carry_in,
    input logic [N-1:0] sum,
    input logic         carry_out,
    input logic [N-1:0] span_prop
);

    logic [N:0] total;
    assign total = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            p_total_r1: assert ({carry_out, sum} == total)
                else $error("R1 total mismatch");
            if (op_a[N-1] && op_b[N-1]) begin
                p_msb_gen_r2: assert (carry_out)
                    else $error("R2 carry-out missing");
            end
            if (!op_a[N-1] && !op_b[N-1]) begin
                p_msb_kill_r2: assert (!carry_out)
                    else $error("R2 spurious carry-out");
            end
            if (op_a == '0 && op_b == '0) begin
                p_zero_ops_r3: assert (sum == {{(N-1){1'b0}}, carry_in} && !carry_out)
                    else $error("R3 zero operands");
            end
            if ((op_a ^ op_b) == '1 && (op_a & op_b) == '0) begin
                p_full_chain_r4: assert (sum == {N{~carry_in}} && carry_out == carry_in)
                    else $error("R4 full chain");
            end
            p_span_prop_r5: assert (span_prop == '0)
                else $error("R5 span to virtual column propagates");
            p_lsb_r6: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
                else $error("R6 bit 0");
        end
    end

endmodule

bind prefix_adder pa_checker #(.N(N)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .span_prop (span_prop)
);

// File: tb/sim_prefix_adder.sv
`timescale 1ns/1ps
module sim_prefix_adder;

    localparam int NW = 16;
    localparam int NS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NW-1:0] a16, b16, s16;
    logic          c16, co16;
    logic [NS-1:0] a4, b4, s4;
    logic          c4, co4;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    prefix_adder #(.N(NW)) u0 (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16)
    );

    prefix_adder #(.N(NS)) u1 (
        .op_a(a4), .op_b(b4), .carry_in(c4), .sum(s4), .carry_out(co4)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive16(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic c);
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        @(posedge clk);
        #1;
    endtask

    task automatic full16(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic c);
        logic [NW:0] exp;
        drive16(a, b, c);
        exp = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, c};
        check("R1 sum", {16'h0, s16}, {16'h0, exp[NW-1:0]});
        check("R2 carry_out", {31'h0, co16}, {31'h0, exp[NW]});
        check("R6 bit0", {31'h0, s16[0]}, {31'h0, a[0] ^ b[0] ^ c});
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a4  = '0; b4  = '0; c4  = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R3: zero operands, carry-in clear (idle state)
        check("R3 idle sum", {16'h0, s16}, 32'h0);
        check("R3 idle carry_out", {31'h0, co16}, 32'h0);
        drive16('0, '0, 1'b1);
        check("R3 cin only sum", {16'h0, s16}, 32'h1);
        check("R3 cin only carry_out", {31'h0, co16}, 32'h0);

        // R4: full propagate chain
        drive16(16'hFFFF, 16'h0000, 1'b1);
        check("R4 chain sum", {16'h0, s16}, 32'h0);
        check("R4 chain carry_out", {31'h0, co16}, 32'h1);
        drive16(16'hA5A5, 16'h5A5A, 1'b1);
        check("R4 split chain sum", {16'h0, s16}, 32'h0);
        check("R4 split chain carry_out", {31'h0, co16}, 32'h1);
        drive16(16'hA5A5, 16'h5A5A, 1'b0);
        check("R4 no-cin chain sum", {16'h0, s16}, 32'hFFFF);
        check("R4 no-cin chain carry_out", {31'h0, co16}, 32'h0);

        // R2: top-column generate and kill
        full16(16'h8000, 16'h8000, 1'b0);
        full16(16'h7FFF, 16'h7FFF, 1'b1);
        full16(16'hFFFF, 16'hFFFF, 1'b1);

        // R1/R2/R6: exhaustive sweep of the 4-bit copy
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [NS:0] e4;
                    @(negedge clk);
                    a4 = i[NS-1:0]; b4 = j[NS-1:0]; c4 = c[0];
                    @(posedge clk);
                    #1;
                    e4 = 5'(i) + 5'(j) + 5'(c);
                    check("R1 sum4", {28'h0, s4}, {28'h0, e4[NS-1:0]});
                    check("R2 carry_out4", {31'h0, co4}, {31'h0, e4[NS]});
                end
            end
        end

        // R5: carry-in set equals carry-in clear plus one; random 16-bit operands
        for (int t = 0; t < 600; t++) begin
            logic [NW-1:0] ra, rb;
            logic [NW:0]   r0, r1;
            ra = NW'($urandom);
            rb = NW'($urandom);
            drive16(ra, rb, 1'b0);
            r0 = {co16, s16};
            drive16(ra, rb, 1'b1);
            r1 = {co16, s16};
            check("R5 cin step", {15'h0, r1}, {15'h0, r0 + 17'd1});
            full16(ra, rb, t[0]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule